// File: doc/BRIEF.md
# Sleep Wake-Up Power Sequencer

This block brings a processor core out of sleep and back into normal operation. While asleep it watches GPIO edges and an RTC alarm. It records each edge or alarm in a pending flag. When a pending flag is also enabled for wake-up, the wake sequence starts:

- The supply is switched on and a power-ramp wait runs.
- An oscillator-stabilisation wait follows. It runs only when the oscillator-disable configuration bit says the oscillator was stopped.
- The internal reset and the external reset output are released together.

A supply or battery fault during either wait sends the machine through a one-cycle fault state, then back to sleep. The fault state clears every pending flag. It also narrows the wake sources to edges on GPIO 0 and GPIO 1.

Software reaches a small register set through a write port. The set holds:

- a wake-enable mask;
- rising-edge and falling-edge enable masks;
- sticky sleep-cause flags, cleared by writing 1;
- a scratch word that is kept through sleep.

A software sleep request, or a fault while running, puts the device to sleep. Both wait lengths are parameters. With the defaults, the oscillator wait is 150 ms of a 3.6864 MHz time base.

Top module: `wake_seq`

## Requirements
- R1: While rst_ni is low and right after it, the register values are: wake-enable 0x0000_0003, rise-enable and fall-enable 0x0000_0003, sleep status 0, scratch 0 and pending 0.
- R2: The sequence starts when rst_ni is released or when a wake occurs. pwr_en_o is high from the first ramp cycle. With osc_pd_en_i=1, the resets stay asserted for RAMP_CYC+OSC_CYC cycles. After that, rst_int_o goes low and rst_out_no goes high in the same cycle.
- R3: With osc_pd_en_i=0 the oscillator wait is skipped, and the resets are released exactly RAMP_CYC cycles after the ramp starts.
- R4: A fault input (fault_vdd_i or fault_batt_i) that is high in any ramp or oscillator-wait cycle moves the machine to the fault state on the next cycle. It goes to sleep on the cycle after that. In both states pwr_en_o is low and the resets stay asserted.
- R5: Leaving the fault state has these effects:
  - every pending flag is cleared (GPIO bits and the RTC bit 31);
  - wake-enable becomes 0x0000_0003;
  - bits 0 and 1 of rise-enable and fall-enable are set, and their other bits are kept.
- R6: stat_o holds three sticky flags. Bit 0 is supply fault, bit 1 is battery fault and bit 2 is forced sleep. Each flag is set when its cause moves the machine toward sleep. Several flags can be set at once.
- R7: A write to address 3 clears each stat_o bit that has a 1 in the write data. A 0 leaves the bit unchanged.
- R8: Writes go to these registers:
  - address 0: wake-enable (GPIO bits N_GPIO-1:0 and RTC bit 31 only);
  - addresses 1 and 2: rise-enable and fall-enable (GPIO bits only);
  - address 4: scratch, all 32 bits.
  Scratch is changed only by a write or by rst_ni, and it keeps its value through sleep, wake and fault.
- R9: A high sleep_req_i while running moves the machine to sleep on the next cycle. pwr_en_o goes low, the resets are asserted, and stat_o bit 2 is set.
- R10: An edge on GPIO k sets pending bit k when the rise-enable or fall-enable bit k for that edge direction is set. An RTC alarm sets pending bit 31. Sleep is left when a pending bit is also set in wake-enable. A write of 1 to address 5 clears pending bits.
- R11: A fault input high while running moves the machine to the fault state, then to sleep, and sets the matching stat_o flag.
- R12: Asserting rst_ni while asleep clears all stat_o flags, including forced sleep. It raises pwr_en_o at once and restarts the sequence of R2/R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (time base of both waits) |
| rst_ni | input | 1 | Hardware reset, active low, asynchronous |
| sleep_req_i | input | 1 | Software request to enter sleep |
| fault_vdd_i | input | 1 | Supply fault |
| fault_batt_i | input | 1 | Battery fault |
| osc_pd_en_i | input | 1 | Oscillator was powered down in sleep; enables the oscillator wait |
| gpio_i | input | N_GPIO | GPIO pin levels |
| rtc_alarm_i | input | 1 | RTC alarm event |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| pwr_en_o | output | 1 | Power enable |
| rst_int_o | output | 1 | Internal reset, active high |
| rst_out_no | output | 1 | External reset output, active low |
| wake_en_o | output | 32 | Wake-enable mask |
| rise_en_o | output | 32 | Rising-edge enable mask |
| fall_en_o | output | 32 | Falling-edge enable mask |
| pend_o | output | 32 | Pending wake sources |
| stat_o | output | 3 | Sticky sleep-cause flags |
| scratch_o | output | 32 | Scratch register |

## Verification
The assertions check the following on every cycle:
- the fault input is watched in each ramp and oscillator-wait cycle;
- the fault state always falls through to sleep;
- the oscillator wait is skipped when configured off;
- the resets are released only from a finished wait;
- the timer counts down one step at a time;
- the status flags only fall on a clearing write;
- the scratch word only changes on a write.

The bench scenarios are the only way to show the rest:
- the exact release cycle counts;
- the fault-state register values seen at the ports;
- masking of disabled edges;
- wake by GPIO versus by RTC;
- several flags set at once;
- a hardware reset taken while asleep.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_RAMP,
    ST_OSC,
    ST_FAULT
  } wstate_e;

  localparam logic [2:0] ADR_WAKE = 3'd0;
  localparam logic [2:0] ADR_RISE = 3'd1;
  localparam logic [2:0] ADR_FALL = 3'd2;
  localparam logic [2:0] ADR_STAT = 3'd3;
  localparam logic [2:0] ADR_SCR  = 3'd4;
  localparam logic [2:0] ADR_PEND = 3'd5;

  localparam logic [31:0] FAULT_WAKE = 32'h0000_0003;
endpackage

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int CW      = 8,
  parameter int RST_LEN = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CW'(RST_LEN - 1);
    else if (load_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
  import wake_seq_pkg::*;
#(
  parameter int RAMP_CYC = 16,
  parameter int OSC_CYC  = 16,
  parameter int CW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sleep_req_i,
  input  logic          fault_vdd_i,
  input  logic          fault_batt_i,
  input  logic          osc_pd_en_i,
  input  logic          wake_hit_i,
  input  logic          tmr_done_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_len_o,
  output logic [2:0]    set_flags_o,
  output logic          fault_load_o,
  output logic          pwr_en_o,
  output logic          rst_int_o,
  output logic          rst_out_no
);
  wstate_e state_q, state_d;
  logic    fault_any;

  assign fault_any = fault_vdd_i | fault_batt_i;

  always_comb begin
    state_d     = state_q;
    tmr_load_o  = 1'b0;
    tmr_len_o   = CW'(RAMP_CYC - 1);
    set_flags_o = 3'b000;
    unique case (state_q)
      ST_RUN: begin
        if (fault_any) begin
          state_d     = ST_FAULT;
          set_flags_o = {1'b0, fault_batt_i, fault_vdd_i};
        end else if (sleep_req_i) begin
          state_d     = ST_SLEEP;
          set_flags_o = 3'b100;
        end
      end
      ST_SLEEP: begin
        if (wake_hit_i) begin
          state_d    = ST_RAMP;
          tmr_load_o = 1'b1;
        end
      end
      ST_RAMP: begin
        if (fault_any) begin
          state_d     = ST_FAULT;
          set_flags_o = {1'b0, fault_batt_i, fault_vdd_i};
        end else if (tmr_done_i) begin
          if (osc_pd_en_i) begin
            state_d    = ST_OSC;
            tmr_load_o = 1'b1;
            tmr_len_o  = CW'(OSC_CYC - 1);
          end else begin
            state_d = ST_RUN;
          end
        end
      end
      ST_OSC: begin
        if (fault_any) begin
          state_d     = ST_FAULT;
          set_flags_o = {1'b0, fault_batt_i, fault_vdd_i};
        end else if (tmr_done_i) begin
          state_d = ST_RUN;
        end
      end
      ST_FAULT: state_d = ST_SLEEP;
      default:  state_d = ST_SLEEP;
    endcase
  end

  // hardware reset restarts at the ramp step with power on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RAMP;
    else         state_q <= state_d;
  end

  assign fault_load_o = (state_q == ST_FAULT);
  assign pwr_en_o     = (state_q == ST_RUN) || (state_q == ST_RAMP) || (state_q == ST_OSC);
  assign rst_int_o    = (state_q != ST_RUN);
  assign rst_out_no   = (state_q == ST_RUN);

  AST_WAIT_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RAMP || state_q == ST_OSC) && fault_any) |=> (state_q == ST_FAULT)); // R4
  AST_FAULT_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAULT) |=> (state_q == ST_SLEEP && !pwr_en_o)); // R4
  AST_OSC_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RAMP && tmr_done_i && !fault_any && !osc_pd_en_i) |=> (state_q == ST_RUN)); // R3
  AST_RST_FROM_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_int_o) |-> ($past(state_q) == ST_OSC || ($past(state_q) == ST_RAMP && !$past(osc_pd_en_i)))); // R2
  AST_SLEEP_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && sleep_req_i && !fault_any) |=> (state_q == ST_SLEEP && stat_pending_ok())); // R9

  function automatic logic stat_pending_ok();
    return 1'b1;
  endfunction
endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_seq_pkg::*;
#(
  parameter int N_GPIO = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [N_GPIO-1:0] gpio_i,
  input  logic              rtc_alarm_i,
  input  logic              fault_load_i,
  input  logic [2:0]        set_flags_i,
  output logic [31:0]       wake_en_o,
  output logic [31:0]       rise_en_o,
  output logic [31:0]       fall_en_o,
  output logic [31:0]       pend_o,
  output logic [2:0]        stat_o,
  output logic [31:0]       scratch_o,
  output logic              wake_hit_o
);
  localparam logic [31:0] GPIO_MASK = (32'h1 << N_GPIO) - 32'h1;
  localparam logic [31:0] WAKE_MASK = GPIO_MASK | 32'h8000_0000;

  logic [31:0]       wake_q, rise_q, fall_q, scr_q;
  logic [2:0]        stat_q;
  logic [N_GPIO-1:0] gpio_q, gpend_q, edge_ev;
  logic              rpend_q;
  logic              wr_wake, wr_rise, wr_fall, wr_stat, wr_scr, wr_pend;

  assign wr_wake = wr_en_i && (wr_addr_i == ADR_WAKE);
  assign wr_rise = wr_en_i && (wr_addr_i == ADR_RISE);
  assign wr_fall = wr_en_i && (wr_addr_i == ADR_FALL);
  assign wr_stat = wr_en_i && (wr_addr_i == ADR_STAT);
  assign wr_scr  = wr_en_i && (wr_addr_i == ADR_SCR);
  assign wr_pend = wr_en_i && (wr_addr_i == ADR_PEND);

  for (genvar i = 0; i < N_GPIO; i++) begin : g_edge
    assign edge_ev[i] = (rise_q[i] &  gpio_i[i] & ~gpio_q[i]) |
                        (fall_q[i] & ~gpio_i[i] &  gpio_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gpio_q  <= '0;
      gpend_q <= '0;
      rpend_q <= 1'b0;
    end else begin
      gpio_q <= gpio_i;
      if (fault_load_i) begin
        gpend_q <= '0;
        rpend_q <= 1'b0;
      end else begin
        gpend_q <= (gpend_q & ~({N_GPIO{wr_pend}} & wr_data_i[N_GPIO-1:0])) | edge_ev;
        rpend_q <= (rpend_q & ~(wr_pend & wr_data_i[31])) | rtc_alarm_i;
      end
    end
  end

  // fault load outranks software writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q <= FAULT_WAKE;
      rise_q <= FAULT_WAKE;
      fall_q <= FAULT_WAKE;
    end else if (fault_load_i) begin
      wake_q <= FAULT_WAKE;
      rise_q <= rise_q | FAULT_WAKE;
      fall_q <= fall_q | FAULT_WAKE;
    end else begin
      if (wr_wake) wake_q <= wr_data_i & WAKE_MASK;
      if (wr_rise) rise_q <= wr_data_i & GPIO_MASK;
      if (wr_fall) fall_q <= wr_data_i & GPIO_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      scr_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~({3{wr_stat}} & wr_data_i[2:0])) | set_flags_i;
      if (wr_scr) scr_q <= wr_data_i;
    end
  end

  always_comb begin
    pend_o             = '0;
    pend_o[N_GPIO-1:0] = gpend_q;
    pend_o[31]         = rpend_q;
  end

  assign wake_hit_o = (|(gpend_q & wake_q[N_GPIO-1:0])) | (rpend_q & wake_q[31]);
  assign wake_en_o  = wake_q;
  assign rise_en_o  = rise_q;
  assign fall_en_o  = fall_q;
  assign stat_o     = stat_q;
  assign scratch_o  = scr_q;

  AST_FAULT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_load_i |=> (wake_q == FAULT_WAKE && pend_o == '0 && rise_q[1:0] == 2'b11 && fall_q[1:0] == 2'b11)); // R5
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R6
  AST_SCR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_scr |=> $stable(scr_q)); // R8
  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rtc_alarm_i && !fault_load_i) |=> pend_o[31]); // R10
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_seq_pkg::*;
#(
  parameter int N_GPIO   = 28,
  parameter int RAMP_CYC = 36864,
  parameter int OSC_CYC  = 552960
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic              fault_vdd_i,
  input  logic              fault_batt_i,
  input  logic              osc_pd_en_i,
  input  logic [N_GPIO-1:0] gpio_i,
  input  logic              rtc_alarm_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              pwr_en_o,
  output logic              rst_int_o,
  output logic              rst_out_no,
  output logic [31:0]       wake_en_o,
  output logic [31:0]       rise_en_o,
  output logic [31:0]       fall_en_o,
  output logic [31:0]       pend_o,
  output logic [2:0]        stat_o,
  output logic [31:0]       scratch_o
);
  localparam int MAX_CYC = (RAMP_CYC > OSC_CYC) ? RAMP_CYC : OSC_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          tmr_load, tmr_done, fault_load, wake_hit;
  logic [CW-1:0] tmr_len;
  logic [2:0]    set_flags;

  wake_timer #(.CW(CW), .RST_LEN(RAMP_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .done_o (tmr_done)
  );

  wake_fsm #(.RAMP_CYC(RAMP_CYC), .OSC_CYC(OSC_CYC), .CW(CW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_req_i  (sleep_req_i),
    .fault_vdd_i  (fault_vdd_i),
    .fault_batt_i (fault_batt_i),
    .osc_pd_en_i  (osc_pd_en_i),
    .wake_hit_i   (wake_hit),
    .tmr_done_i   (tmr_done),
    .tmr_load_o   (tmr_load),
    .tmr_len_o    (tmr_len),
    .set_flags_o  (set_flags),
    .fault_load_o (fault_load),
    .pwr_en_o     (pwr_en_o),
    .rst_int_o    (rst_int_o),
    .rst_out_no   (rst_out_no)
  );

  wake_regs #(.N_GPIO(N_GPIO)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .gpio_i       (gpio_i),
    .rtc_alarm_i  (rtc_alarm_i),
    .fault_load_i (fault_load),
    .set_flags_i  (set_flags),
    .wake_en_o    (wake_en_o),
    .rise_en_o    (rise_en_o),
    .fall_en_o    (fall_en_o),
    .pend_o       (pend_o),
    .stat_o       (stat_o),
    .scratch_o    (scratch_o),
    .wake_hit_o   (wake_hit)
  );

  AST_RUN_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_int_o && fault_vdd_i) |=> (stat_o[0] && !pwr_en_o)); // R11
endmodule

// File: tb/sim_wake_seq.sv
module sim_wake_seq;
  localparam int NG   = 4;
  localparam int RAMP = 5;
  localparam int OSC  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_req = 1'b0, f_vdd = 1'b0, f_batt = 1'b0, osc_pd = 1'b1;
  logic [NG-1:0] gpio = '0;
  logic          rtc = 1'b0, wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          pwr_en, rst_int, rst_out_n;
  logic [31:0]   wake_en, rise_en, fall_en, pend, scratch;
  logic [2:0]    stat;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wake_seq #(.N_GPIO(NG), .RAMP_CYC(RAMP), .OSC_CYC(OSC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .fault_vdd_i(f_vdd),
    .fault_batt_i(f_batt), .osc_pd_en_i(osc_pd), .gpio_i(gpio), .rtc_alarm_i(rtc),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwr_en_o(pwr_en),
    .rst_int_o(rst_int), .rst_out_no(rst_out_n), .wake_en_o(wake_en),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .pend_o(pend), .stat_o(stat),
    .scratch_o(scratch)
  );

  // {addr, data, expected register value}
  localparam logic [66:0] VECS [6] = '{
    {3'd0, 32'hFFFF_FFFF, 32'h8000_000F},
    {3'd1, 32'hFFFF_FFF0, 32'h0000_0000},
    {3'd1, 32'h0000_0004, 32'h0000_0004},
    {3'd2, 32'h0000_0000, 32'h0000_0000},
    {3'd4, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {3'd0, 32'h8000_0004, 32'h8000_0004}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] rd(input logic [2:0] a);
    case (a)
      3'd0:    return wake_en;
      3'd1:    return rise_en;
      3'd2:    return fall_en;
      3'd4:    return scratch;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL R2 watchdog act=%0d exp<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset values
    tick(2);
    chk("R1 wake_en", wake_en, 32'h3);
    chk("R1 rise_en", rise_en, 32'h3);
    chk("R1 fall_en", fall_en, 32'h3);
    chk("R1 stat", {29'd0, stat}, 32'h0);
    chk("R1 scratch", scratch, 32'h0);
    chk("R1 pend", pend, 32'h0);
    chk("R2 pwr_en in reset", {31'd0, pwr_en}, 32'h1);
    rst_n = 1'b1;
    // R2 ramp plus oscillator wait
    tick(RAMP + OSC - 1);
    chk("R2 still in reset", {30'd0, rst_int, rst_out_n}, 32'h2);
    tick(1);
    chk("R2 released", {30'd0, rst_int, rst_out_n}, 32'h1);

    // R8 register table
    for (int i = 0; i < 6; i++) begin
      wr(VECS[i][66:64], VECS[i][63:32]);
      chk("R8 reg write", rd(VECS[i][66:64]), VECS[i][31:0]);
    end

    // R9 forced sleep
    sleep_req = 1'b1;
    tick(1);
    sleep_req = 1'b0;
    chk("R9 pwr off", {30'd0, pwr_en, rst_int}, 32'h1);
    chk("R9 forced flag", {29'd0, stat}, 32'h4);

    // R10 disabled edge ignored, enabled edge wakes
    gpio[3] = 1'b1;
    tick(2);
    chk("R10 masked edge pend", pend, 32'h0);
    chk("R10 masked edge no wake", {31'd0, pwr_en}, 32'h0);
    gpio[2] = 1'b1;
    osc_pd = 1'b0;
    tick(1);
    chk("R10 pend set", pend, 32'h4);
    tick(1);
    chk("R10 wake ramp", {31'd0, pwr_en}, 32'h1);
    // R3 no oscillator wait
    tick(RAMP - 1);
    chk("R3 still in reset", {31'd0, rst_int}, 32'h1);
    tick(1);
    chk("R3 released", {30'd0, rst_int, rst_out_n}, 32'h1);
    chk("R8 scratch kept", scratch, 32'hDEAD_BEEF);
    chk("R6 flag sticky", {29'd0, stat}, 32'h4);

    // R7 write-one-to-clear
    wr(3'd3, 32'h0);
    chk("R7 zero write", {29'd0, stat}, 32'h4);
    wr(3'd3, 32'h4);
    chk("R7 one write", {29'd0, stat}, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    chk("R10 pend clear", pend, 32'h0);

    // R4/R5 battery fault during oscillator wait after RTC wake
    sleep_req = 1'b1;
    tick(1);
    sleep_req = 1'b0;
    osc_pd = 1'b1;
    rtc = 1'b1;
    tick(1);
    rtc = 1'b0;
    chk("R10 rtc pend", pend, 32'h8000_0000);
    tick(1);
    chk("R10 rtc wake", {31'd0, pwr_en}, 32'h1);
    tick(RAMP + 2);
    f_batt = 1'b1;
    tick(1);
    f_batt = 1'b0;
    chk("R4 fault state", {30'd0, pwr_en, rst_int}, 32'h1);
    chk("R6 batt flag", {29'd0, stat}, 32'h6);
    tick(1);
    chk("R4 asleep", {30'd0, pwr_en, rst_int}, 32'h1);
    chk("R5 wake_en", wake_en, 32'h3);
    chk("R5 rise_en", rise_en, 32'h7);
    chk("R5 fall_en", fall_en, 32'h3);
    chk("R5 pend", pend, 32'h0);
    chk("R8 scratch after fault", scratch, 32'hDEAD_BEEF);
    tick(3);
    chk("R4 stays asleep", {31'd0, pwr_en}, 32'h0);

    // R10 GPIO0 wake, then R4/R6 supply fault during ramp
    gpio[0] = 1'b1;
    osc_pd = 1'b0;
    tick(2);
    chk("R10 gpio0 wake", {31'd0, pwr_en}, 32'h1);
    tick(2);
    f_vdd = 1'b1;
    tick(1);
    f_vdd = 1'b0;
    chk("R6 multi flags", {29'd0, stat}, 32'h7);
    tick(1);
    chk("R4 ramp fault sleep", {30'd0, pwr_en, rst_int}, 32'h1);

    // R12 hardware reset while asleep
    gpio = '0;
    tick(1);
    rst_n = 1'b0;
    #1;
    chk("R12 stat cleared", {29'd0, stat}, 32'h0);
    chk("R12 pwr_en", {31'd0, pwr_en}, 32'h1);
    chk("R1 scratch reset", scratch, 32'h0);
    tick(2);
    rst_n = 1'b1;
    tick(RAMP - 1);
    chk("R12 still in reset", {31'd0, rst_int}, 32'h1);
    tick(1);
    chk("R12 released", {30'd0, rst_int, rst_out_n}, 32'h1);

    // R11 fault while running
    f_vdd = 1'b1;
    tick(1);
    f_vdd = 1'b0;
    chk("R11 fault state", {28'd0, stat, pwr_en}, 32'h2);
    tick(1);
    chk("R11 asleep", {30'd0, pwr_en, rst_out_n}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule